// File: doc/BRIEF.md
# Serial ADC Result Frame Shifter

This block is the digital read port of a low-power successive-approximation converter. It takes a parallel conversion result, two extra sub-LSB bits and a channel-identity bit, and sends them out one bit at a time as a fixed 16-bit frame. A host drives the serial clock `sclk` and an active-low select `cs_n`. While `cs_n` is high the converter is in shutdown: the data output is not driven and any frame in progress is abandoned. All inputs are sampled by the system clock `clk`, which runs well above the serial clock. Each output reacts one `clk` cycle after the edge that caused it.

The level of `sclk` at the moment `cs_n` falls selects the mode. If `sclk` is low, the block uses serial-clock mode. The host's second falling `sclk` edge latches the sample and starts the conversion, and every falling edge moves the frame on by one bit. If `sclk` is high, the block uses self-timed mode. The sample is latched as `cs_n` falls, and the first frame bit is a done flag that reads 0 until the converter pulses `eoc_strobe`. The frame is three ones, the channel-identity bit, the result MSB first, then the two sub-bits. When the frame is finished, zeros follow for as long as the host keeps clocking.

The controller has five states: `ST_SHDN`, `ST_EXT_ARM`, `ST_INT_CONV`, `ST_SHIFT` and `ST_TRAIL`. The transitions are:
- `ST_SHDN` goes to `ST_EXT_ARM` when select falls with `sclk` low.
- `ST_SHDN` goes to `ST_INT_CONV` when select falls with `sclk` high.
- `ST_EXT_ARM` goes to `ST_SHIFT` on the sampling edge.
- `ST_INT_CONV` goes to `ST_SHIFT` on `eoc_strobe`.
- `ST_SHIFT` goes to `ST_TRAIL` on the falling edge after the last frame bit.
- Every state other than `ST_SHDN` returns to `ST_SHDN` as soon as `cs_n` is high.

After reset the block waits for a falling edge on `cs_n`.

Top module: `adc_frame_shifter`

## Requirements
- R1: In serial-clock mode, after the k-th falling `sclk` edge (k = 1..16), `sdo` carries frame bit k. Frame bits 1 to 3 are 1, bit 4 is the channel-identity bit, bits 5 to 14 are `res_data[9]` down to `res_data[0]`, and bits 15 and 16 are `res_sub[1]` then `res_sub[0]`. Before the first falling edge, `sdo` is 0.
- R2: With `SINGLE_INPUT` = 0, the channel-identity bit equals `res_chid`: 0 for channel 0, 1 for channel 1. With `SINGLE_INPUT` = 1, it is always 1.
- R3: While the block is selected, `sdo` changes only one `clk` cycle after a falling `sclk` edge or after `eoc_strobe`. A rising `sclk` edge leaves it unchanged.
- R4: `sdo_oe` is 0 whenever `cs_n` is high, including after reset.
- R5: A falling edge of `cs_n` seen while `sclk` is low selects serial-clock mode. In that mode, frame bit 1 appears on the first falling `sclk` edge with no `eoc_strobe`.
- R6: In serial-clock mode, `sample_pulse` is high for one `clk` cycle after the second falling `sclk` edge, and not after the first.
- R7: After frame bit 16, each further falling `sclk` edge leaves `sdo` at 0 while `cs_n` stays low.
- R8: Raising `cs_n` in the middle of a frame returns the block to shutdown. The next select then runs a complete, fresh frame from bit 1.
- R9: A falling edge of `cs_n` seen while `sclk` is high selects self-timed mode. The sample is latched and `sample_pulse` fires at select. `sdo` reads 0 until `eoc_strobe`, then reads 1 (bit 1). Each later falling `sclk` edge then presents frame bits 2 to 16.
- R10: `res_data`, `res_sub` and `res_chid` are latched at the sampling point. Changes to them afterwards do not alter the frame in progress.
- R11: `sdo_oe` is 1 from one `clk` after `cs_n` falls until `cs_n` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select; high means shutdown |
| sclk | input | 1 | Host serial clock |
| eoc_strobe | input | 1 | One-cycle pulse marking the end of a self-timed conversion |
| res_data | input | DATA_W | Parallel conversion result |
| res_sub | input | SUB_W | Sub-LSB bits |
| res_chid | input | 1 | Channel identity, 0 or 1 |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Output enable; 0 means high impedance |
| sample_pulse | output | 1 | One-cycle pulse when the sample is latched |

## Verification
The bench builds two copies of the block with the default widths: a 10-bit result, two sub-bits, three leading ones and sampling on the second falling edge. One copy uses `SINGLE_INPUT` = 0 and the other `SINGLE_INPUT` = 1. Both receive the same stimulus. This lets one run compare the channel-identity bit of the two-input variant with the fixed 1 of the single-input variant. With the short 16-bit frame, a full frame, the trailing zeros, an abort and a self-timed read all fit within a few thousand cycles.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

    typedef enum logic [2:0] {
        ST_SHDN     = 3'd0,
        ST_EXT_ARM  = 3'd1,
        ST_INT_CONV = 3'd2,
        ST_SHIFT    = 3'd3,
        ST_TRAIL    = 3'd4
    } shf_state_e;

endpackage

// File: rtl/adc_edge_det.sv
// Registers one input level and flags a high-to-low transition.
module adc_edge_det #(
    parameter bit RESET_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);

    logic q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RESET_LEVEL;
        end else begin
            q <= din;
        end
    end

    assign fall = q & ~din;

endmodule

// File: rtl/adc_frame_pack.sv
// Assembles the output frame: leading ones, identity bit, result, sub-bits.
module adc_frame_pack #(
    parameter int DATA_W       = 10,
    parameter int SUB_W        = 2,
    parameter int LEAD_ONES    = 3,
    parameter bit SINGLE_INPUT = 1'b0,
    localparam int FRAME_W     = LEAD_ONES + 1 + DATA_W + SUB_W
) (
    input  logic [DATA_W-1:0]  data,
    input  logic [SUB_W-1:0]   sub,
    input  logic               chid,
    output logic [FRAME_W-1:0] frame
);

    logic id_bit;

    generate
        if (SINGLE_INPUT) begin : g_single
            assign id_bit = 1'b1;
        end else begin : g_dual
            assign id_bit = chid;
        end
    endgenerate

    assign frame = {{LEAD_ONES{1'b1}}, id_bit, data, sub};

endmodule

// File: rtl/adc_frame_shreg.sv
// Frame shift register. A full load keeps bit 1 at the top; a skip load
// drops the bits already presented before the sampling edge.
module adc_frame_shreg #(
    parameter int FRAME_W = 16,
    parameter int SKIP    = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_full,
    input  logic               load_skip,
    input  logic               shift_en,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               msb
);

    logic [FRAME_W-1:0] sreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load_full) begin
            sreg_q <= frame_in;
        end else if (load_skip) begin
            sreg_q <= frame_in << SKIP;
        end else if (shift_en) begin
            sreg_q <= {sreg_q[FRAME_W-2:0], 1'b0};
        end
    end

    assign msb = sreg_q[FRAME_W-1];

endmodule

// File: rtl/adc_frame_fsm.sv
// Mode choice, edge counting, abort and output selection.
module adc_frame_fsm
    import adc_frame_pkg::*;
#(
    parameter int FRAME_W     = 16,
    parameter int SAMPLE_EDGE = 2,
    parameter int CNT_W       = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       cs_fall,
    input  logic       sclk_fall,
    input  logic       eoc_strobe,
    input  logic       shreg_msb,
    output logic       load_full,
    output logic       load_skip,
    output logic       shift_en,
    output logic       sample_pulse,
    output logic       sdo,
    output logic       sdo_oe,
    output shf_state_e state_o
);

    localparam logic [CNT_W-1:0] ARM_LAST   = CNT_W'(SAMPLE_EDGE - 1);
    localparam logic [CNT_W-1:0] SAMPLE_CNT = CNT_W'(SAMPLE_EDGE);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_W);

    shf_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             sample_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_SHDN;
            cnt_q    <= '0;
            sample_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            sample_q <= load_full | load_skip;
        end
    end

    // next state and datapath controls
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        load_full = 1'b0;
        load_skip = 1'b0;
        shift_en  = 1'b0;
        if (cs_n && state_q != ST_SHDN) begin
            state_d = ST_SHDN;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_SHDN: begin
                    cnt_d = '0;
                    if (cs_fall) begin
                        if (sclk) begin
                            state_d   = ST_INT_CONV;
                            load_full = 1'b1;
                        end else begin
                            state_d = ST_EXT_ARM;
                        end
                    end
                end
                ST_EXT_ARM: begin
                    if (sclk_fall) begin
                        if (cnt_q == ARM_LAST) begin
                            state_d   = ST_SHIFT;
                            cnt_d     = SAMPLE_CNT;
                            load_skip = 1'b1;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_INT_CONV: begin
                    if (eoc_strobe) begin
                        state_d = ST_SHIFT;
                        cnt_d   = CNT_W'(1);
                    end
                end
                ST_SHIFT: begin
                    if (sclk_fall) begin
                        shift_en = 1'b1;
                        if (cnt_q == FRAME_LAST) begin
                            state_d = ST_TRAIL;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_TRAIL: begin
                    state_d = ST_TRAIL;
                end
                default: begin
                    state_d = ST_SHDN;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        sdo    = 1'b0;
        sdo_oe = ~cs_n & (state_q != ST_SHDN);
        unique case (state_q)
            ST_SHDN:     sdo = 1'b0;
            ST_EXT_ARM:  sdo = (cnt_q != '0);
            ST_INT_CONV: sdo = 1'b0;
            ST_SHIFT:    sdo = shreg_msb;
            ST_TRAIL:    sdo = 1'b0;
            default:     sdo = 1'b0;
        endcase
    end

    assign sample_pulse = sample_q;
    assign state_o      = state_q;

endmodule

// File: rtl/adc_frame_shifter.sv
// Top level of the serial result read port.
module adc_frame_shifter
    import adc_frame_pkg::*;
#(
    parameter int DATA_W       = 10,
    parameter int SUB_W        = 2,
    parameter int LEAD_ONES    = 3,
    parameter int SAMPLE_EDGE  = 2,
    parameter bit SINGLE_INPUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              eoc_strobe,
    input  logic [DATA_W-1:0] res_data,
    input  logic [SUB_W-1:0]  res_sub,
    input  logic              res_chid,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              sample_pulse
);

    localparam int FRAME_W = LEAD_ONES + 1 + DATA_W + SUB_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int SKIP    = SAMPLE_EDGE - 1;

    logic               cs_fall;
    logic               sclk_fall;
    logic [FRAME_W-1:0] frame;
    logic               load_full;
    logic               load_skip;
    logic               shift_en;
    logic               shreg_msb;
    shf_state_e         fsm_state;

    adc_edge_det #(.RESET_LEVEL(1'b1)) u_cs_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cs_n),
        .fall (cs_fall)
    );

    adc_edge_det #(.RESET_LEVEL(1'b0)) u_sclk_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sclk),
        .fall (sclk_fall)
    );

    adc_frame_pack #(
        .DATA_W      (DATA_W),
        .SUB_W       (SUB_W),
        .LEAD_ONES   (LEAD_ONES),
        .SINGLE_INPUT(SINGLE_INPUT)
    ) u_pack (
        .data (res_data),
        .sub  (res_sub),
        .chid (res_chid),
        .frame(frame)
    );

    adc_frame_shreg #(
        .FRAME_W(FRAME_W),
        .SKIP   (SKIP)
    ) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_full(load_full),
        .load_skip(load_skip),
        .shift_en (shift_en),
        .frame_in (frame),
        .msb      (shreg_msb)
    );

    adc_frame_fsm #(
        .FRAME_W    (FRAME_W),
        .SAMPLE_EDGE(SAMPLE_EDGE),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .cs_fall     (cs_fall),
        .sclk_fall   (sclk_fall),
        .eoc_strobe  (eoc_strobe),
        .shreg_msb   (shreg_msb),
        .load_full   (load_full),
        .load_skip   (load_skip),
        .shift_en    (shift_en),
        .sample_pulse(sample_pulse),
        .sdo         (sdo),
        .sdo_oe      (sdo_oe),
        .state_o     (fsm_state)
    );

endmodule

// File: rtl/adc_frame_shifter_chk.sv
module adc_frame_shifter_chk
    import adc_frame_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sclk,
    input logic       eoc_strobe,
    input logic       sdo,
    input logic       sdo_oe,
    input logic       sample_pulse,
    input shf_state_e state
);

    // R3
    sdo_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && $past(sdo_oe) && !($past(sclk, 2) && !$past(sclk)) && !$past(eoc_strobe))
        |-> $stable(sdo));

    // R5
    ext_mode_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n, 2) && !$past(cs_n) && !$past(sclk)) |-> (state == ST_EXT_ARM));

    // R6
    sample_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pulse |-> (($past(sclk, 2) && !$past(sclk)) || ($past(cs_n, 2) && !$past(cs_n))));

    // R7
    trail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRAIL && !cs_n) |=> !sdo);

    // R8
    abort_shdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (state == ST_SHDN));

    // R9
    eoc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_INT_CONV && sdo) |-> $past(eoc_strobe));

endmodule

bind adc_frame_shifter adc_frame_shifter_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .sclk        (sclk),
    .eoc_strobe  (eoc_strobe),
    .sdo         (sdo),
    .sdo_oe      (sdo_oe),
    .sample_pulse(sample_pulse),
    .state       (fsm_state)
);

// File: tb/adc_frame_shifter_tb_top.sv
`timescale 1ns/1ps
module adc_frame_shifter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       eoc_strobe = 1'b0;
    logic [9:0] res_data = '0;
    logic [1:0] res_sub = '0;
    logic       res_chid = 1'b0;
    logic       sdo, sdo_oe, sample_pulse;
    logic       sdo_pd, oe_pd, samp_pd;

    int n_chk = 0;
    int n_bad = 0;
    int samp_cnt = 0;
    bit done = 0;

    always #5 clk = ~clk;

    adc_frame_shifter dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .eoc_strobe(eoc_strobe),
        .res_data(res_data), .res_sub(res_sub), .res_chid(res_chid),
        .sdo(sdo), .sdo_oe(sdo_oe), .sample_pulse(sample_pulse)
    );

    adc_frame_shifter #(.SINGLE_INPUT(1'b1)) dut_pd_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .eoc_strobe(eoc_strobe),
        .res_data(res_data), .res_sub(res_sub), .res_chid(res_chid),
        .sdo(sdo_pd), .sdo_oe(oe_pd), .sample_pulse(samp_pd)
    );

    always @(posedge clk) if (sample_pulse) samp_cnt <= samp_cnt + 1;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclk_up();
        sclk = 1'b1;
        wait_n(3);
    endtask

    task automatic sclk_down();
        sclk = 1'b0;
        wait_n(3);
    endtask

    function automatic logic [15:0] mk_frame(input logic [9:0] d, input logic [1:0] s, input logic c);
        return {3'b111, c, d, s};
    endfunction

    task automatic run_ext(input logic [9:0] d, input logic [1:0] s, input logic c);
        logic [15:0] f;
        int base;
        f = mk_frame(d, s, c);
        res_data = d; res_sub = s; res_chid = c;
        sclk = 1'b0;
        wait_n(2);
        cs_n = 1'b0;
        wait_n(3);
        chk("R11 oe after select", sdo_oe, 1);
        chk("R1 idle before first edge", sdo, 0);
        base = samp_cnt;
        for (int k = 1; k <= 16; k++) begin
            sclk_up();
            if (k > 1) chk("R3 rise keeps bit", sdo, f[16-(k-1)]);
            sclk_down();
            chk("R1 frame bit", sdo, f[16-k]);
            if (k == 1) begin
                chk("R5 bit1 without eoc", sdo, 1);
                chk("R6 no sample on edge 1", samp_cnt - base, 0);
            end
            if (k == 2) begin
                chk("R6 sample on edge 2", samp_cnt - base, 1);
                res_data = ~d; res_sub = ~s; res_chid = ~c;
            end
            if (k == 4) begin
                chk("R2 chid two-input", sdo, c);
                chk("R2 chid single-input", sdo_pd, 1);
            end
            if (k > 2) chk("R10 latched frame", sdo, f[16-k]);
        end
        for (int k = 0; k < 2; k++) begin
            sclk_up();
            sclk_down();
            chk("R7 trailing zero", sdo, 0);
        end
        chk("R11 oe held", sdo_oe, 1);
        cs_n = 1'b1;
        wait_n(3);
        chk("R4 hi-z after deselect", sdo_oe, 0);
    endtask

    task automatic run_abort();
        res_data = 10'h155; res_sub = 2'b11; res_chid = 1'b1;
        sclk = 1'b0;
        wait_n(2);
        cs_n = 1'b0;
        wait_n(3);
        for (int k = 0; k < 6; k++) begin
            sclk_up();
            sclk_down();
        end
        cs_n = 1'b1;
        wait_n(3);
        chk("R8 abort hi-z", sdo_oe, 0);
        chk("R4 abort sdo_pd oe", oe_pd, 0);
        wait_n(4);
        run_ext(10'h0C3, 2'b01, 1'b0);
    endtask

    task automatic run_int(input logic [9:0] d, input logic [1:0] s, input logic c);
        logic [15:0] f;
        int base;
        f = mk_frame(d, s, c);
        res_data = d; res_sub = s; res_chid = c;
        sclk = 1'b1;
        wait_n(3);
        base = samp_cnt;
        cs_n = 1'b0;
        wait_n(3);
        chk("R9 sample at select", samp_cnt - base, 1);
        chk("R11 oe internal", sdo_oe, 1);
        chk("R9 eoc low", sdo, 0);
        res_data = ~d; res_sub = ~s; res_chid = ~c;
        wait_n(10);
        chk("R9 eoc still low", sdo, 0);
        eoc_strobe = 1'b1;
        wait_n(1);
        eoc_strobe = 1'b0;
        wait_n(2);
        chk("R9 eoc high", sdo, 1);
        for (int k = 2; k <= 16; k++) begin
            sclk_down();
            chk("R9 internal frame bit", sdo, f[16-k]);
            if (k == 4) chk("R10 internal chid latched", sdo, c);
            sclk_up();
            chk("R3 rise keeps bit internal", sdo, f[16-k]);
        end
        sclk_down();
        chk("R7 trailing zero internal", sdo, 0);
        cs_n = 1'b1;
        wait_n(3);
        chk("R4 hi-z after internal", sdo_oe, 0);
        sclk = 1'b0;
        wait_n(2);
    endtask

    initial begin
        wait_n(4);
        chk("R4 reset oe", sdo_oe, 0);
        chk("R4 reset sdo", sdo, 0);
        rst_n = 1'b1;
        wait_n(3);
        chk("R4 idle oe", sdo_oe, 0);
        chk("R6 no sample in reset", samp_cnt, 0);
        run_ext(10'h2A5, 2'b10, 1'b0);
        run_ext(10'h3FF, 2'b01, 1'b1);
        run_abort();
        run_int(10'h19C, 2'b10, 1'b1);
        run_ext(10'h001, 2'b00, 1'b0);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule